// File: doc/BRIEF.md
# Four-Entry Instruction TLB Replacement Tracker

This block keeps the least-recently-used order of a four-entry instruction TLB. The order is held as six pairwise-order bits in the top of a 32-bit MMU control word. Each bit records which of two entries was used more recently. Every use of an entry moves it to most recently used by applying a fixed clear mask and a fixed set mask to the upper byte of the word. The other 26 bits of the word are stored but never changed by those updates.

A hit strobe reports the entry that matched a lookup. A refill request asks for a victim. The block reports the victim on `victim_idx` and, on the same edge as the refill, marks that victim as most recently used. Software can load the whole word through a write port, and the current word is always visible on `ctrl_word`.

The victim is decoded from the state by four patterns, tested in a fixed order. A state that matches none of the patterns raises `state_err` and names entry 0. All pins are plain control and status signals with no handshake. Each strobe acts on the rising edge where it is high and cannot be back-pressured.

Top module: `itlb_lru_tracker`

## Requirements
- R1: Hits and refills change only bits 31:26 of `ctrl_word`; bits 25:0 keep their value unless software writes them.
- R2: A hit on entry 0 (`hit_idx`=0) clears bits 31:29 of the word on the next edge, which is an AND of the upper byte with 0x1F.
- R3: A hit on entry 1 ANDs the upper byte with 0xE7 and then ORs it with 0x80.
- R4: A hit on entry 2 ANDs the upper byte with 0xFB and then ORs it with 0x50.
- R5: A hit on entry 3 ORs the upper byte with 0x2C and clears no bit.
- R6: `victim_idx` is decoded from upper byte B, testing in this order and taking the first match: (B&0xE0)==0xE0 gives 0; (B&0x98)==0x18 gives 1; (B&0x54)==0x04 gives 2; (B&0x2C)==0x00 gives 3.
- R7: When B matches none of the R6 patterns (for example B=0xA8), `state_err` is 1 and `victim_idx` is 0. Otherwise `state_err` is 0.
- R8: On an edge with `refill_req` high, the state is updated as a hit on the victim shown before that edge.
- R9: A software write (`wr_en`) loads `wr_data` into the whole word and overrides any hit or refill on the same edge.
- R10: When a hit and a refill arrive on the same edge, the refill update is applied and the hit is dropped.
- R11: After reset `ctrl_word` is 0. That state decodes to victim 3 with `state_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | A lookup hit the entry named by hit_idx |
| hit_idx | input | 2 | Entry that was hit |
| refill_req | input | 1 | Replace the victim and mark it most recently used |
| wr_en | input | 1 | Software write strobe for the control word |
| wr_data | input | 32 | Value written to the control word |
| ctrl_word | output | 32 | Current control word, order bits on top |
| victim_idx | output | 2 | Entry to replace next |
| state_err | output | 1 | The order bits match no legal pattern |

## Verification
A wrong mask bit shows up in `ctrl_word` one edge after the hit that uses it. It also changes the victim decoded in that same cycle, so the error spreads into every later refill choice. A swap in the decode priority shows up at once on `victim_idx` for any state that matches more than one pattern. A weak error check shows up as a missing `state_err` on illegal states loaded by software. Refill and write precedence are seen one edge after the conflicting strobes, as a word that differs from the expected winner.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
  localparam int ENTRIES   = 4;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int BYTE_W    = 8;

  typedef logic [BYTE_W-1:0] ubyte_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam ubyte_t CLR_MASK [ENTRIES] = '{8'h1F, 8'hE7, 8'hFB, 8'hFF};
  localparam ubyte_t SET_MASK [ENTRIES] = '{8'h00, 8'h80, 8'h50, 8'h2C};
  localparam ubyte_t SEL_MASK [ENTRIES] = '{8'hE0, 8'h98, 8'h54, 8'h2C};
  localparam ubyte_t SEL_PATT [ENTRIES] = '{8'hE0, 8'h18, 8'h04, 8'h00};
endpackage

// File: rtl/itlb_lru_update.sv
module itlb_lru_update
  import itlb_lru_pkg::*;
(
  input  ubyte_t cur_byte,
  input  idx_t   use_idx,
  output ubyte_t nxt_byte
);
  ubyte_t cand [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_mask
    assign cand[g] = (cur_byte & CLR_MASK[g]) | SET_MASK[g];
  end

  assign nxt_byte = cand[use_idx];
endmodule

// File: rtl/itlb_lru_victim.sv
module itlb_lru_victim
  import itlb_lru_pkg::*;
(
  input  ubyte_t cur_byte,
  output idx_t   victim,
  output logic   illegal
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pat
    assign match[g] = (cur_byte & SEL_MASK[g]) == SEL_PATT[g];
  end

  always_comb begin
    victim  = '0;
    illegal = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        victim  = idx_t'(i);
        illegal = 1'b0;
      end
    end
  end
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
  import itlb_lru_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [1:0]        hit_idx,
  input  logic              refill_req,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [1:0]        victim_idx,
  output logic              state_err
);
  localparam int LOW_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] word_q;
  ubyte_t            top_byte, upd_byte;
  idx_t              vict, use_idx;
  logic              bad;

  assign top_byte = word_q[WORD_W-1 -: BYTE_W];
  assign use_idx  = refill_req ? vict : hit_idx;

  itlb_lru_victim u_victim (
    .cur_byte (top_byte),
    .victim   (vict),
    .illegal  (bad)
  );

  itlb_lru_update u_update (
    .cur_byte (top_byte),
    .use_idx  (use_idx),
    .nxt_byte (upd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= wr_data;
    end else if (refill_req || hit_valid) begin
      word_q <= {upd_byte, word_q[LOW_W-1:0]};
    end
  end

  assign ctrl_word  = word_q;
  assign victim_idx = vict;
  assign state_err  = bad;
endmodule

// File: rtl/itlb_lru_checker.sv
module itlb_lru_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hit_valid,
  input logic [1:0]  hit_idx,
  input logic        refill_req,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] ctrl_word,
  input logic [1:0]  victim_idx,
  input logic        state_err
);
  p_low_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ctrl_word[25:0] == $past(ctrl_word[25:0]));

  p_entry0_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_idx == 2'd0 && !refill_req && !wr_en) |=> ctrl_word[31:29] == 3'b000);

  p_entry3_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_idx == 2'd3 && !refill_req && !wr_en)
      |=> (ctrl_word[29] && ctrl_word[27] && ctrl_word[26]));

  p_err_victim0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_err |-> victim_idx == 2'd0);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_word == $past(wr_data));

  p_refill_e0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !wr_en && victim_idx == 2'd0) |=> ctrl_word[31:29] == 3'b000);
endmodule

bind itlb_lru_tracker itlb_lru_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_valid  (hit_valid),
  .hit_idx    (hit_idx),
  .refill_req (refill_req),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .ctrl_word  (ctrl_word),
  .victim_idx (victim_idx),
  .state_err  (state_err)
);

// File: tb/test_itlb_lru_tracker.sv
`timescale 1ns/1ps
module test_itlb_lru_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        hit_valid = 0;
  logic [1:0]  hit_idx = 0;
  logic        refill_req = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] ctrl_word;
  logic [1:0]  victim_idx;
  logic        state_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] model = 0;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  itlb_lru_tracker i_itlb_lru_tracker (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_idx(hit_idx),
    .refill_req(refill_req), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_word(ctrl_word), .victim_idx(victim_idx), .state_err(state_err)
  );

  function automatic logic [7:0] f_upd(logic [7:0] b, logic [1:0] e);
    case (e)
      2'd0: return b & 8'h1F;
      2'd1: return (b & 8'hE7) | 8'h80;
      2'd2: return (b & 8'hFB) | 8'h50;
      default: return b | 8'h2C;
    endcase
  endfunction

  function automatic logic [2:0] f_vic(logic [7:0] b);
    if ((b & 8'hE0) == 8'hE0) return 3'b000;
    if ((b & 8'h98) == 8'h18) return 3'b001;
    if ((b & 8'h54) == 8'h04) return 3'b010;
    if ((b & 8'h2C) == 8'h00) return 3'b011;
    return 3'b100;
  endfunction

  task automatic cmp(string t, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic check_all(string t);
    logic [2:0] v;
    v = f_vic(model[31:24]);
    cmp(t, "ctrl_word", ctrl_word, model);
    cmp(v[2] ? "R7" : "R6", "victim_idx", {30'd0, victim_idx}, {30'd0, v[1:0]});
    cmp("R7", "state_err", {31'd0, state_err}, {31'd0, v[2]});
  endtask

  task automatic step(logic h, logic [1:0] hi, logic rf, logic w, logic [31:0] wd);
    logic [2:0] v;
    hit_valid = h; hit_idx = hi; refill_req = rf; wr_en = w; wr_data = wd;
    v = f_vic(model[31:24]);
    if (w) begin
      model = wd; tag = "R9";
    end else if (rf) begin
      model[31:24] = f_upd(model[31:24], v[1:0]); tag = h ? "R10" : "R8";
    end else if (h) begin
      model[31:24] = f_upd(model[31:24], hi);
      case (hi)
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R5";
      endcase
    end else tag = "R1";
    @(negedge clk);
    hit_valid = 0; refill_req = 0; wr_en = 0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check_all("R11");
    rst_n = 1;
    @(negedge clk);
    check_all("R11");

    step(0, 0, 0, 1, 32'h0012_3456);
    for (int e = 0; e < 4; e++) step(1, 2'(e), 0, 0, 0);
    step(0, 0, 0, 1, 32'hA800_00FF);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 32'hFFFF_FFFF);
    step(1, 2'd1, 0, 0, 0);
    step(1, 2'd2, 1, 0, 0);
    step(1, 2'd3, 1, 1, 32'h5A5A_A5A5);
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[2:1], r[5:3] == 3'd0, r[9:6] == 4'd0, $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule